// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Recency Ranks

This block caches eight virtual-to-physical page mappings for a 16-bit byte-addressed machine that uses 256-byte pages. The upper byte of an address is the virtual page number (VPN) and the lower byte is the offset within the page. A lookup compares the VPN against all eight entries at once. On a hit, the block returns the physical address. If the operation is not permitted by the entry, it reports a protection fault. If no valid entry matches, it reports a miss.

After a miss, the surrounding walker installs a mapping through the refill port. The new mapping goes into a free slot if one exists. Otherwise it displaces the least recently used mapping. The displaced mapping is presented on a writeback port, so that its modified state can be returned to the page table.

Each slot keeps a 3-bit recency rank, where 0 is the most recent. Every successful access and every refill reorders the ranks. A flush empties the buffer, for example when a new page table base is loaded for a different process.

Top module: `xlat_buffer`

## Requirements
- R1: After reset, and one cycle after `flush` is sampled high, every entry is invalid. Any later lookup misses until a refill installs a mapping.
- R2: The VPN is `lookupAddr[15:8]` and the offset is `lookupAddr[7:0]`. On a hit, `respAddr` equals {PPN, offset}, one cycle after the lookup is sampled. In every other cycle `respAddr` is zero.
- R3: Exactly one of `respHit`, `respMiss` and `respFault` pulses, one cycle after each accepted lookup. `respMiss` pulses when no valid entry holds the VPN.
- R4: A write to an entry that lacks write permission, or a read from an entry that lacks read permission, gives `respFault` rather than `respHit`. The entry's dirty bit and the recency order stay unchanged.
- R5: A write hit marks the entry dirty. A read hit leaves the dirty bit as it was.
- R6: On a hit, that entry's rank becomes 0. Every valid entry whose rank was below the entry's old rank moves one place older, and no two valid entries share a rank.
- R7: While any entry is invalid, a refill takes the invalid entry with the lowest index, and no valid mapping is displaced.
- R8: When all entries are valid, a refill replaces the entry of rank 7, which is the least recently used. The new entry receives rank 0.
- R9: When a refill displaces a valid entry, `wbValid` pulses one cycle later, with that entry's VPN, PPN and dirty bit on `wbVpn`, `wbPpn` and `wbDirty`. A refill into an invalid entry gives no pulse.
- R10: Only one operation is taken per cycle, with priority flush, then refill, then lookup. A lookup presented together with a flush or a refill produces no response, and a refill presented together with a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupAddr | input | 16 | Virtual byte address |
| lookupWrite | input | 1 | 1 = write access, 0 = read access |
| fillValid | input | 1 | Install a mapping this cycle |
| fillVpn | input | 8 | VPN of the installed mapping |
| fillPpn | input | 8 | PPN of the installed mapping |
| fillCanRead | input | 1 | Read permission of the installed mapping |
| fillCanWrite | input | 1 | Write permission of the installed mapping |
| fillDirty | input | 1 | Initial dirty bit of the installed mapping |
| respHit | output | 1 | Lookup hit with permission |
| respMiss | output | 1 | Lookup found no mapping |
| respFault | output | 1 | Lookup hit but the operation is not permitted |
| respAddr | output | 16 | Physical address on a hit, else zero |
| wbValid | output | 1 | A valid mapping was displaced |
| wbVpn | output | 8 | VPN of the displaced mapping |
| wbPpn | output | 8 | PPN of the displaced mapping |
| wbDirty | output | 1 | Dirty bit of the displaced mapping |

## Verification
Every result of this block passes through one register stage. A lookup's hit, miss or fault flag and its physical address appear in the cycle after the request is sampled, and so does a refill's writeback pulse. The bench changes inputs on the falling edge and reads outputs on the next falling edge, which is half a period after the single rising edge that produces them. The recency order cannot be read from the ports, so it is checked through eviction: after a chosen pattern of hits, faults and misses, each refill must write back exactly the mapping that the expected order makes oldest, carrying the dirty state that the earlier writes produced.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int ADDR_W  = 16;
  parameter int OFFS_W  = 8;
  parameter int ENTRY_N = 8;
  localparam int PAGE_W = ADDR_W - OFFS_W;
  localparam int SLOT_W = $clog2(ENTRY_N);
  localparam int RANK_W = SLOT_W;

  typedef logic [SLOT_W-1:0] slot_t;

  // Strobes from control to datapath, one operation per cycle
  typedef struct packed {
    logic  doFlush;   // invalidate all entries
    logic  doFill;    // install mapping into slot
    logic  doTouch;   // permitted hit on slot
    logic  setDirty;  // write hit on slot
    logic  capWb;     // slot holds a valid mapping being displaced
    logic  capResp;   // accepted lookup this cycle
    slot_t slot;      // target entry
  } xlat_strobe_t;
endpackage

// File: rtl/xlat_dpath.sv
module xlat_dpath
  import xlat_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  xlat_strobe_t                    strb,
  input  logic [PAGE_W-1:0]               lkVpn,
  input  logic [OFFS_W-1:0]               lkOffs,
  input  logic [PAGE_W-1:0]               fillVpn,
  input  logic [PAGE_W-1:0]               fillPpn,
  input  logic                            fillDirty,
  input  logic                            fillRd,
  input  logic                            fillWr,
  output logic [ENTRY_N-1:0]              matchVec,
  output logic [ENTRY_N-1:0]              validVec,
  output logic [ENTRY_N-1:0]              rdOkVec,
  output logic [ENTRY_N-1:0]              wrOkVec,
  output logic [ENTRY_N-1:0][RANK_W-1:0]  rankVec,
  output logic [ADDR_W-1:0]               respAddr,
  output logic [PAGE_W-1:0]               wbVpn,
  output logic [PAGE_W-1:0]               wbPpn,
  output logic                            wbDirty
);

  localparam logic [RANK_W-1:0] OLDEST = RANK_W'(ENTRY_N - 1);

  logic [ENTRY_N-1:0][PAGE_W-1:0] tagQ;
  logic [ENTRY_N-1:0][PAGE_W-1:0] ppnQ;
  logic [ENTRY_N-1:0]             validQ;
  logic [ENTRY_N-1:0]             dirtyQ;
  logic [ENTRY_N-1:0]             rdQ;
  logic [ENTRY_N-1:0]             wrQ;
  logic [ENTRY_N-1:0][RANK_W-1:0] rankQ;

  logic [RANK_W-1:0] oldRank;
  logic              reorder;

  assign oldRank = rankQ[strb.slot];
  assign reorder = strb.doFill | strb.doTouch;

  // Parallel tag compare
  generate
    for (genvar g = 0; g < ENTRY_N; g++) begin : gen_cmp
      assign matchVec[g] = validQ[g] && (tagQ[g] == lkVpn);
    end
  endgenerate

  assign validVec = validQ;
  assign rdOkVec  = rdQ;
  assign wrOkVec  = wrQ;
  assign rankVec  = rankQ;

  // Entry storage and recency reordering
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRY_N; i++) begin
        validQ[i] <= 1'b0;
        dirtyQ[i] <= 1'b0;
        rdQ[i]    <= 1'b0;
        wrQ[i]    <= 1'b0;
        tagQ[i]   <= '0;
        ppnQ[i]   <= '0;
        rankQ[i]  <= OLDEST;
      end
    end else if (strb.doFlush) begin
      for (int i = 0; i < ENTRY_N; i++) begin
        validQ[i] <= 1'b0;
        rankQ[i]  <= OLDEST;
      end
    end else begin
      for (int i = 0; i < ENTRY_N; i++) begin
        if (reorder) begin
          if (strb.slot == SLOT_W'(i))
            rankQ[i] <= '0;
          else if (validQ[i] && (rankQ[i] < oldRank))
            rankQ[i] <= rankQ[i] + RANK_W'(1);
        end
        if (strb.doFill && (strb.slot == SLOT_W'(i))) begin
          validQ[i] <= 1'b1;
          tagQ[i]   <= fillVpn;
          ppnQ[i]   <= fillPpn;
          dirtyQ[i] <= fillDirty;
          rdQ[i]    <= fillRd;
          wrQ[i]    <= fillWr;
        end else if (strb.setDirty && (strb.slot == SLOT_W'(i))) begin
          dirtyQ[i] <= 1'b1;
        end
      end
    end
  end

  // Response address and writeback capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respAddr <= '0;
      wbVpn    <= '0;
      wbPpn    <= '0;
      wbDirty  <= 1'b0;
    end else begin
      respAddr <= (strb.capResp && strb.doTouch) ? {ppnQ[strb.slot], lkOffs} : '0;
      if (strb.capWb) begin
        wbVpn   <= tagQ[strb.slot];
        wbPpn   <= ppnQ[strb.slot];
        wbDirty <= dirtyQ[strb.slot];
      end
    end
  end

  // Rank-value decode used by the uniqueness checks
  logic [ENTRY_N-1:0][ENTRY_N-1:0] rankHit;
  always_comb begin
    for (int r = 0; r < ENTRY_N; r++)
      for (int i = 0; i < ENTRY_N; i++)
        rankHit[r][i] = (rankQ[i] == RANK_W'(r));
  end

  // R1
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doFlush |=> (validQ == '0));

  // R5
  write_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDirty |=> dirtyQ[$past(strb.slot)]);

  // R6
  touch_newest_chk: assert property (@(posedge clk) disable iff (!rstN)
    reorder |=> (rankQ[$past(strb.slot)] == '0));

  generate
    for (genvar r = 0; r < ENTRY_N; r++) begin : gen_rank_chk
      // R6
      rank_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
        $countones(validQ & rankHit[r]) <= 1);
    end
  endgenerate

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            flush,
  input  logic                            lookupValid,
  input  logic                            lookupWrite,
  input  logic                            fillValid,
  input  logic [ENTRY_N-1:0]              matchVec,
  input  logic [ENTRY_N-1:0]              validVec,
  input  logic [ENTRY_N-1:0]              rdOkVec,
  input  logic [ENTRY_N-1:0]              wrOkVec,
  input  logic [ENTRY_N-1:0][RANK_W-1:0]  rankVec,
  output xlat_strobe_t                    strb,
  output logic                            respHit,
  output logic                            respMiss,
  output logic                            respFault,
  output logic                            wbValid
);

  localparam logic [RANK_W-1:0] OLDEST = RANK_W'(ENTRY_N - 1);

  slot_t hitSlot;
  slot_t freeSlot;
  slot_t lruSlot;
  slot_t victim;
  logic  hitAny;
  logic  anyFree;
  logic  permOk;
  logic  lkAct;
  logic  fillAct;

  // Priority encoders: lowest index wins
  always_comb begin
    hitSlot  = '0;
    freeSlot = '0;
    lruSlot  = '0;
    for (int i = ENTRY_N - 1; i >= 0; i--) begin
      if (matchVec[i])           hitSlot  = SLOT_W'(i);
      if (!validVec[i])          freeSlot = SLOT_W'(i);
      if (rankVec[i] == OLDEST)  lruSlot  = SLOT_W'(i);
    end
  end

  assign hitAny  = |matchVec;
  assign anyFree = ~&validVec;
  assign victim  = anyFree ? freeSlot : lruSlot;
  assign permOk  = lookupWrite ? wrOkVec[hitSlot] : rdOkVec[hitSlot];
  assign fillAct = fillValid && !flush;
  assign lkAct   = lookupValid && !flush && !fillValid;

  always_comb begin
    strb          = '0;
    strb.doFlush  = flush;
    strb.doFill   = fillAct;
    strb.doTouch  = lkAct && hitAny && permOk;
    strb.setDirty = lkAct && hitAny && permOk && lookupWrite;
    strb.capWb    = fillAct && validVec[victim];
    strb.capResp  = lkAct;
    strb.slot     = fillAct ? victim : hitSlot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respHit   <= 1'b0;
      respMiss  <= 1'b0;
      respFault <= 1'b0;
      wbValid   <= 1'b0;
    end else begin
      respHit   <= lkAct && hitAny && permOk;
      respMiss  <= lkAct && !hitAny;
      respFault <= lkAct && hitAny && !permOk;
      wbValid   <= strb.capWb;
    end
  end

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  // R3
  resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({respHit, respMiss, respFault}));

  // R7
  victim_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doFill && anyFree) |-> !validVec[strb.slot]);

  // R8
  victim_oldest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doFill && !anyFree) |-> (rankVec[strb.slot] == OLDEST));

  // R10
  busy_no_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flush || fillValid) |=> !(respHit || respMiss || respFault));

  // R4
  fault_no_touch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkAct && hitAny && !permOk) |-> !(strb.doTouch || strb.setDirty));

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic              lookupWrite,
  input  logic              fillValid,
  input  logic [PAGE_W-1:0] fillVpn,
  input  logic [PAGE_W-1:0] fillPpn,
  input  logic              fillCanRead,
  input  logic              fillCanWrite,
  input  logic              fillDirty,
  output logic              respHit,
  output logic              respMiss,
  output logic              respFault,
  output logic [ADDR_W-1:0] respAddr,
  output logic              wbValid,
  output logic [PAGE_W-1:0] wbVpn,
  output logic [PAGE_W-1:0] wbPpn,
  output logic              wbDirty
);

  xlat_strobe_t                   strb;
  logic [ENTRY_N-1:0]             matchVec;
  logic [ENTRY_N-1:0]             validVec;
  logic [ENTRY_N-1:0]             rdOkVec;
  logic [ENTRY_N-1:0]             wrOkVec;
  logic [ENTRY_N-1:0][RANK_W-1:0] rankVec;

  xlat_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .lookupValid(lookupValid),
    .lookupWrite(lookupWrite),
    .fillValid  (fillValid),
    .matchVec   (matchVec),
    .validVec   (validVec),
    .rdOkVec    (rdOkVec),
    .wrOkVec    (wrOkVec),
    .rankVec    (rankVec),
    .strb       (strb),
    .respHit    (respHit),
    .respMiss   (respMiss),
    .respFault  (respFault),
    .wbValid    (wbValid)
  );

  xlat_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .lkVpn    (lookupAddr[ADDR_W-1:OFFS_W]),
    .lkOffs   (lookupAddr[OFFS_W-1:0]),
    .fillVpn  (fillVpn),
    .fillPpn  (fillPpn),
    .fillDirty(fillDirty),
    .fillRd   (fillCanRead),
    .fillWr   (fillCanWrite),
    .matchVec (matchVec),
    .validVec (validVec),
    .rdOkVec  (rdOkVec),
    .wrOkVec  (wrOkVec),
    .rankVec  (rankVec),
    .respAddr (respAddr),
    .wbVpn    (wbVpn),
    .wbPpn    (wbPpn),
    .wbDirty  (wbDirty)
  );

endmodule

// File: tb/test_xlat_buffer.sv
module test_xlat_buffer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        lookupValid = 1'b0;
  logic [15:0] lookupAddr = '0;
  logic        lookupWrite = 1'b0;
  logic        fillValid = 1'b0;
  logic [7:0]  fillVpn = '0;
  logic [7:0]  fillPpn = '0;
  logic        fillCanRead = 1'b0;
  logic        fillCanWrite = 1'b0;
  logic        fillDirty = 1'b0;
  logic        respHit, respMiss, respFault, wbValid, wbDirty;
  logic [15:0] respAddr;
  logic [7:0]  wbVpn, wbPpn;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xlat_buffer i_xlat_buffer (
    .clk(clk), .rstN(rstN), .flush(flush),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr), .lookupWrite(lookupWrite),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .fillCanRead(fillCanRead), .fillCanWrite(fillCanWrite), .fillDirty(fillDirty),
    .respHit(respHit), .respMiss(respMiss), .respFault(respFault), .respAddr(respAddr),
    .wbValid(wbValid), .wbVpn(wbVpn), .wbPpn(wbPpn), .wbDirty(wbDirty)
  );

  task automatic chkEq(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Lookup; outputs sampled one falling edge later
  task automatic doLookup(input logic [15:0] addr, input bit wr, input bit expH,
                          input bit expM, input bit expF, input logic [15:0] expPa,
                          input string req);
    @(negedge clk);
    lookupValid = 1'b1; lookupAddr = addr; lookupWrite = wr;
    @(negedge clk);
    lookupValid = 1'b0; lookupWrite = 1'b0;
    chkEq(req, "respHit", 32'(respHit), 32'(expH));
    chkEq(req, "respMiss", 32'(respMiss), 32'(expM));
    chkEq(req, "respFault", 32'(respFault), 32'(expF));
    chkEq(req, "respAddr", 32'(respAddr), 32'(expPa));
  endtask

  task automatic doFill(input logic [7:0] vpn, input logic [7:0] ppn, input bit rd,
                        input bit wr, input bit expWb, input logic [7:0] expVpn,
                        input logic [7:0] expPpn, input bit expDirty, input string req);
    @(negedge clk);
    fillValid = 1'b1; fillVpn = vpn; fillPpn = ppn;
    fillCanRead = rd; fillCanWrite = wr; fillDirty = 1'b0;
    @(negedge clk);
    fillValid = 1'b0;
    chkEq(req, "wbValid", 32'(wbValid), 32'(expWb));
    if (expWb) begin
      chkEq(req, "wbVpn", 32'(wbVpn), 32'(expVpn));
      chkEq(req, "wbPpn", 32'(wbPpn), 32'(expPpn));
      chkEq(req, "wbDirty", 32'(wbDirty), 32'(expDirty));
    end
  endtask

  task automatic doFlush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic runReset();
    // R1: idle outputs and empty buffer after reset
    chkEq("R1", "respHit after reset", 32'(respHit), 0);
    chkEq("R1", "wbValid after reset", 32'(wbValid), 0);
    chkEq("R1", "respAddr after reset", 32'(respAddr), 0);
    doLookup(16'h1234, 1'b0, 0, 1, 0, 16'h0, "R1");
    doLookup(16'h0000, 1'b1, 0, 1, 0, 16'h0, "R3");
  endtask

  task automatic runPerm();
    doFlush();
    doFill(8'h20, 8'h12, 1, 0, 0, 0, 0, 0, "R7");
    doLookup(16'h2001, 1'b1, 0, 0, 1, 16'h0, "R4");
    doLookup(16'h2001, 1'b0, 1, 0, 0, 16'h1201, "R2");
    doFill(8'h21, 8'h13, 0, 1, 0, 0, 0, 0, "R7");
    doLookup(16'h21ff, 1'b0, 0, 0, 1, 16'h0, "R4");
    doLookup(16'h21ff, 1'b1, 1, 0, 0, 16'h13ff, "R2");
    doLookup(16'h2201, 1'b0, 0, 1, 0, 16'h0, "R3");
  endtask

  task automatic runLru();
    doFlush();
    for (int i = 0; i < 8; i++)
      doFill(8'(8'h40 + i), 8'(8'h80 + i), 1, (i != 7), 0, 0, 0, 0, "R7");
    doLookup(16'h4100, 1'b1, 1, 0, 0, 16'h8100, "R5");
    doLookup(16'h4010, 1'b0, 1, 0, 0, 16'h8010, "R6");
    doLookup(16'h4733, 1'b1, 0, 0, 1, 16'h0, "R4");
    // expected order newest first: 40 41 47 46 45 44 43 42
    doFill(8'h50, 8'h90, 1, 1, 1, 8'h42, 8'h82, 0, "R8");
    doFill(8'h51, 8'h91, 1, 1, 1, 8'h43, 8'h83, 0, "R9");
    doLookup(16'h44aa, 1'b0, 1, 0, 0, 16'h84aa, "R6");
    doFill(8'h52, 8'h92, 1, 1, 1, 8'h45, 8'h85, 0, "R6");
    doFill(8'h53, 8'h93, 1, 1, 1, 8'h46, 8'h86, 0, "R8");
    doFill(8'h54, 8'h94, 1, 1, 1, 8'h47, 8'h87, 0, "R4");
    doFill(8'h55, 8'h95, 1, 1, 1, 8'h41, 8'h81, 1, "R5");
    doLookup(16'h4100, 1'b0, 0, 1, 0, 16'h0, "R3");
    doFill(8'h56, 8'h96, 1, 1, 1, 8'h40, 8'h80, 0, "R5");
    doLookup(16'h5677, 1'b1, 1, 0, 0, 16'h9677, "R2");
  endtask

  task automatic runPrio();
    doFlush();
    doLookup(16'h5677, 1'b0, 0, 1, 0, 16'h0, "R1");
    doFill(8'h30, 8'h33, 1, 1, 0, 0, 0, 0, "R7");
    // refill and lookup together: lookup dropped
    @(negedge clk);
    fillValid = 1'b1; fillVpn = 8'h31; fillPpn = 8'h34;
    fillCanRead = 1'b1; fillCanWrite = 1'b1;
    lookupValid = 1'b1; lookupAddr = 16'h3000; lookupWrite = 1'b0;
    @(negedge clk);
    fillValid = 1'b0; lookupValid = 1'b0;
    chkEq("R10", "no response beside refill",
          32'({respHit, respMiss, respFault}), 0);
    doLookup(16'h3105, 1'b0, 1, 0, 0, 16'h3405, "R10");
    // flush and refill together: refill discarded
    @(negedge clk);
    flush = 1'b1; fillValid = 1'b1; fillVpn = 8'h32; fillPpn = 8'h35;
    @(negedge clk);
    flush = 1'b0; fillValid = 1'b0;
    chkEq("R10", "wbValid beside flush", 32'(wbValid), 0);
    doLookup(16'h3200, 1'b0, 0, 1, 0, 16'h0, "R10");
    doLookup(16'h3000, 1'b0, 0, 1, 0, 16'h0, "R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    runReset();
    runPerm();
    runLru();
    runPrio();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule